// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block drives an external single-conversion analog-to-digital converter through a start/done handshake. For each request it returns one averaged 10-bit reading on the requested channel. When a request is accepted, the sequencer powers the converter, selects the channel and the supply reference, and runs a clock-enable divider for the converter. It then issues one warm-up conversion whose result is thrown away. After that it runs five further conversions back to back, each started only after the previous one reports done, and sums their results.

After the final conversion the converter is switched off. The sum is divided by five with truncation. For the supply-voltage channel (channel 2), the average is also scaled by roughly 1.46 in fixed point. The result appears with a one-cycle valid pulse and is held until the next result. A request that arrives while a sequence is running is dropped.

Top module: `adc_avg_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, adc_en_o, adc_ref_o, adc_start_o, adc_clk_en_o and valid_o are 0, and adc_ch_o and res_o are 0.
- R2: A request seen while idle makes adc_en_o and adc_ref_o 1 on the next cycle, with adc_ch_o equal to the requested channel number (2-bit binary).
- R3: While adc_en_o is 1, adc_clk_en_o is high for one cycle in every 8, first on the 8th cycle of enable. It is 0 whenever adc_en_o is 0.
- R4: adc_start_o is a one-cycle pulse. The first pulse comes in the first enabled cycle, and each later pulse comes on the cycle after adc_done_i. Exactly six pulses are issued per request.
- R5: The sample returned by the first conversion of a sequence has no effect on the result.
- R6: For channels 0, 1 and 3, res_o equals the sum of the five later samples divided by 5, truncated toward zero.
- R7: For channel 2, res_o equals (avg × 187) >> 7, where avg is the truncated mean of R6.
- R8: On the cycle after the sixth adc_done_i, adc_en_o is 0 and valid_o is 1 for exactly one cycle. res_o holds its value until the next valid pulse.
- R9: A request while a sequence is running is ignored. The channel does not change and no extra conversion is started.
- R10: Five full-scale samples (1023) produce 1023 on channels 0, 1 and 3, and 1494 on channel 2, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request for one averaged reading |
| req_ch_i | input | 2 | Channel for the request |
| adc_dout_i | input | 10 | Converter sample, valid with adc_done_i |
| adc_done_i | input | 1 | Converter reports a finished conversion |
| adc_en_o | output | 1 | Converter power/enable |
| adc_ch_o | output | 2 | Converter channel select |
| adc_ref_o | output | 1 | Supply reference selected |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_clk_en_o | output | 1 | Converter clock enable, system clock divided by 8 |
| res_o | output | 11 | Averaged (and, for channel 2, scaled) result |
| valid_o | output | 1 | One-cycle pulse with a new result |

## Verification
The bench chooses a warm-up sample that is very different from the others. A design that averaged the warm-up conversion, or that dropped the first real sample in its place, returns a visibly wrong mean. Sums that are not multiples of five expose rounding instead of truncation. Full-scale samples on the supply channel expose an accumulator or product that is too narrow, since those would wrap to a small value. A second request injected mid-sequence catches a design that restarts or switches channel. A per-cycle model also catches a start issued before done, a seventh conversion, or a converter left enabled after the last sample.

// File: rtl/adc_avg_pkg.sv
// Shared types for the averaging ADC sequencer.
package adc_avg_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
// Clock-enable divider for the converter.
// Produces a one-cycle tick every PRESC cycles while run_i is high.
// The count restarts from zero each time run_i drops.
// Assumes PRESC >= 2.
module adc_clk_div #(
    parameter int PRESC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(PRESC);

    logic [CW-1:0] cnt_q;

    // Count enabled cycles modulo PRESC.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PRESC - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == CW'(PRESC - 1));

    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> run_i);
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion sequencer.
// Accepts a request only while idle. It then issues NAVG+1 start pulses,
// each one after the previous done, and flags which done carries a sample
// that counts (add) and which one ends the sequence (last).
// Assumes the converter never reports done in the same cycle as a start.
module adc_seq_fsm
    import adc_avg_pkg::*;
#(
    parameter int CH_W = 2,
    parameter int NAVG = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [CH_W-1:0] req_ch_i,
    input  logic            done_i,
    output logic            start_o,
    output logic            en_o,
    output logic [CH_W-1:0] ch_o,
    output logic            clr_o,
    output logic            add_o,
    output logic            last_o
);
    localparam int CNT_W = $clog2(NAVG + 1);

    seq_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;

    // Sequence state, conversion index and latched channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            ch_q    <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (req_i) begin
                    ch_q    <= req_ch_i;
                    cnt_q   <= '0;
                    state_q <= SEQ_START;
                end
                SEQ_START: state_q <= SEQ_WAIT;
                SEQ_WAIT: if (done_i) begin
                    if (cnt_q == CNT_W'(NAVG)) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= SEQ_START;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Decode handshake and datapath controls from the state.
    always_comb begin
        start_o = (state_q == SEQ_START);
        en_o    = (state_q != SEQ_IDLE);
        clr_o   = (state_q == SEQ_IDLE) && req_i;
        add_o   = (state_q == SEQ_WAIT) && done_i && (cnt_q != '0);
        last_o  = (state_q == SEQ_WAIT) && done_i && (cnt_q == CNT_W'(NAVG));
    end

    assign ch_o = ch_q;

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r2_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> en_o);
    a_r9_ch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && $past(en_o)) |-> $stable(ch_o));
    a_r8_off_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !en_o);
endmodule

// File: rtl/adc_avg_math.sv
// Accumulator, divide-by-NAVG and optional supply scaling.
// Clears on clr_i and adds the sample on add_i. On last_i it registers
// floor(sum/NAVG), scaled by SCALE_NUM/2^SCALE_SH when the channel is
// SUPPLY_CH and SCALE_EN is set, and pulses valid_o for one cycle.
module adc_avg_math #(
    parameter int ADC_W     = 10,
    parameter int RES_W     = 11,
    parameter int CH_W      = 2,
    parameter int NAVG      = 5,
    parameter int SCALE_EN  = 1,
    parameter int SCALE_NUM = 187,
    parameter int SCALE_SH  = 7,
    parameter int SUPPLY_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic             last_i,
    input  logic [CH_W-1:0]  ch_i,
    input  logic [ADC_W-1:0] sample_i,
    output logic [RES_W-1:0] res_o,
    output logic             valid_o
);
    localparam int MAXS   = (1 << ADC_W) - 1;
    localparam int ACC_W  = $clog2(NAVG * MAXS + 1);
    localparam int PROD_W = ADC_W + $clog2(SCALE_NUM + 1);

    logic [ACC_W-1:0]  sum_q;
    logic [ACC_W-1:0]  sum_fin;
    logic [ACC_W-1:0]  quot;
    logic [ADC_W-1:0]  avg;
    logic [RES_W-1:0]  res_d;

    assign sum_fin = sum_q + ACC_W'(sample_i);
    assign quot    = sum_fin / ACC_W'(NAVG);
    assign avg     = quot[ADC_W-1:0];

    generate
        if (SCALE_EN != 0) begin : g_scale
            logic [PROD_W-1:0] prod;
            logic [PROD_W-1:0] shifted;
            // Fixed-point supply scaling, channel-selected.
            always_comb begin
                prod    = PROD_W'(avg) * PROD_W'(SCALE_NUM);
                shifted = prod >> SCALE_SH;
                res_d   = (ch_i == CH_W'(SUPPLY_CH)) ? shifted[RES_W-1:0]
                                                     : RES_W'(avg);
            end
        end else begin : g_plain
            assign res_d = RES_W'(avg);
        end
    endgenerate

    // Accumulate counted samples; register the result on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            res_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_i;
            if (clr_i) begin
                sum_q <= '0;
            end else if (add_i && !last_i) begin
                sum_q <= sum_fin;
            end
            if (last_i) begin
                res_o <= res_d;
            end
        end
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= ACC_W'((NAVG - 1) * MAXS));
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(res_o));
endmodule

// File: rtl/adc_avg_seq.sv
// Top of the averaging ADC conversion sequencer.
// Joins the handshake sequencer, the converter clock divider and the
// averaging datapath. Assumes the converter holds adc_dout_i valid in the
// cycle adc_done_i is high.
module adc_avg_seq #(
    parameter int ADC_W     = 10,
    parameter int CH_W      = 2,
    parameter int NAVG      = 5,
    parameter int PRESC     = 8,
    parameter int SCALE_EN  = 1,
    parameter int SCALE_NUM = 187,
    parameter int SCALE_SH  = 7,
    parameter int SUPPLY_CH = 2,
    parameter int RES_W     = ADC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CH_W-1:0]  req_ch_i,
    input  logic [ADC_W-1:0] adc_dout_i,
    input  logic             adc_done_i,
    output logic             adc_en_o,
    output logic [CH_W-1:0]  adc_ch_o,
    output logic             adc_ref_o,
    output logic             adc_start_o,
    output logic             adc_clk_en_o,
    output logic [RES_W-1:0] res_o,
    output logic             valid_o
);
    logic clr, add, last;

    adc_seq_fsm #(.CH_W(CH_W), .NAVG(NAVG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_ch_i(req_ch_i),
        .done_i(adc_done_i), .start_o(adc_start_o), .en_o(adc_en_o),
        .ch_o(adc_ch_o), .clr_o(clr), .add_o(add), .last_o(last)
    );

    adc_clk_div #(.PRESC(PRESC)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(adc_en_o), .tick_o(adc_clk_en_o)
    );

    adc_avg_math #(
        .ADC_W(ADC_W), .RES_W(RES_W), .CH_W(CH_W), .NAVG(NAVG),
        .SCALE_EN(SCALE_EN), .SCALE_NUM(SCALE_NUM), .SCALE_SH(SCALE_SH),
        .SUPPLY_CH(SUPPLY_CH)
    ) u_math (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .add_i(add), .last_i(last),
        .ch_i(adc_ch_o), .sample_i(adc_dout_i), .res_o(res_o), .valid_o(valid_o)
    );

    // Supply reference is selected whenever the converter is on.
    assign adc_ref_o = adc_en_o;
endmodule

// File: tb/sim_adc_avg_seq.sv
module sim_adc_avg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;
    localparam int PRESC      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  req_ch_i = 2'd0;
    logic [9:0]  adc_dout_i = '0;
    logic        adc_done_i = 1'b0;
    logic        adc_en_o, adc_ref_o, adc_start_o, adc_clk_en_o, valid_o;
    logic [1:0]  adc_ch_o;
    logic [10:0] res_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int samp [6];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_avg_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_ch_i(req_ch_i),
        .adc_dout_i(adc_dout_i), .adc_done_i(adc_done_i),
        .adc_en_o(adc_en_o), .adc_ch_o(adc_ch_o), .adc_ref_o(adc_ref_o),
        .adc_start_o(adc_start_o), .adc_clk_en_o(adc_clk_en_o),
        .res_o(res_o), .valid_o(valid_o)
    );

    // Behavioural converter: done LAT cycles after a start; sample k of each
    // six-conversion sequence comes from samp[k].
    int cd = 0;
    int nstart = 0;
    int pend = 0;
    always @(posedge clk) begin
        adc_done_i <= 1'b0;
        if (adc_start_o) begin
            cd = LAT;
            pend = samp[nstart % 6];
            nstart = nstart + 1;
        end else if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
                adc_done_i <= 1'b1;
                adc_dout_i <= 10'(pend);
            end
        end
    end

    function automatic int expect_res(int sum, int ch);
        int avg;
        avg = sum / 5;
        if (ch == 2) return (avg * 187) / 128;
        return avg;
    endfunction

    // Reference model, advanced once per clock from pre-edge inputs.
    int  m_busy = 0, m_en = 0, m_start = 0, m_valid = 0, m_n = 0;
    int  m_sum = 0, m_ch = 0, m_res = 0, m_div = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_en = 0; m_start = 0; m_valid = 0; m_n = 0;
            m_sum = 0; m_ch = 0; m_res = 0; m_div = 0;
        end else begin
            if (m_en != 0) m_div = (m_div + 1) % PRESC; else m_div = 0;
            m_valid = 0;
            m_start = 0;
            if (m_busy == 0) begin
                if (req_i) begin
                    m_busy = 1; m_en = 1; m_start = 1;
                    m_ch = int'(req_ch_i); m_n = 0; m_sum = 0;
                end
            end else if (adc_done_i) begin
                if (m_n > 0) m_sum = m_sum + int'(adc_dout_i);
                if (m_n == 5) begin
                    m_busy = 0; m_en = 0; m_valid = 1;
                    m_res = expect_res(m_sum, m_ch);
                end else begin
                    m_start = 1;
                end
                m_n = m_n + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Compare every signal against the model between edges.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 adc_en_o", int'(adc_en_o), m_en);
            chk("R2 adc_ref_o", int'(adc_ref_o), m_en);
            chk("R9 adc_ch_o", int'(adc_ch_o), m_ch);
            chk("R4 adc_start_o", int'(adc_start_o), m_start);
            chk("R3 adc_clk_en_o", int'(adc_clk_en_o),
                (m_en != 0 && m_div == PRESC - 1) ? 1 : 0);
            chk("R8 valid_o", int'(valid_o), m_valid);
            chk("R6/R7 res_o", int'(res_o), m_res);
        end
    end

    task automatic run_case(string tag, int ch, int w, int a, int b, int c,
                            int d, int e, int exp);
        int guard;
        samp[0] = w; samp[1] = a; samp[2] = b;
        samp[3] = c; samp[4] = d; samp[5] = e;
        @(negedge clk);
        req_i = 1'b1; req_ch_i = 2'(ch);
        @(negedge clk);
        req_i = 1'b0;
        guard = 0;
        while (!valid_o && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        chk(tag, int'(res_o), exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1 reset en", int'(adc_en_o), 0);
        chk("R1 reset start", int'(adc_start_o), 0);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset res", int'(res_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset clk_en", int'(adc_clk_en_o), 0);
        chk("R1 after reset ch", int'(adc_ch_o), 0);

        run_case("R6 ch0 mean", 0, 900, 100, 200, 300, 400, 500, 300);
        run_case("R5 warm-up discarded", 1, 1023, 0, 0, 0, 0, 7, 1);
        run_case("R7 supply scale", 2, 0, 512, 512, 512, 512, 512, 748);
        run_case("R10 full scale ch3", 3, 0, 1023, 1023, 1023, 1023, 1023, 1023);
        run_case("R10 full scale supply", 2, 5, 1023, 1023, 1023, 1023, 1023, 1494);
        run_case("R6 truncation", 0, 1000, 1, 1, 1, 0, 1, 0);
        run_case("R7 supply small", 2, 77, 9, 10, 11, 12, 13, 16);

        // R9: second request mid-sequence is dropped
        samp[0] = 3; samp[1] = 10; samp[2] = 20;
        samp[3] = 30; samp[4] = 40; samp[5] = 50;
        @(negedge clk);
        req_i = 1'b1; req_ch_i = 2'd1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (10) @(negedge clk);
        req_i = 1'b1; req_ch_i = 2'd3;
        @(negedge clk);
        req_i = 1'b0;
        for (int g = 0; g < 500 && !valid_o; g++) @(negedge clk);
        chk("R9 result of first request", int'(res_o), 30);
        chk("R9 channel kept", int'(adc_ch_o), 1);
        repeat (20) @(negedge clk);
        chk("R9 no extra sequence", int'(adc_en_o), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule